// File: doc/BRIEF.md
# Saturating Clear-on-Read Error Counters

This block keeps four error statistics for a 10/100 Mb/s Ethernet line interface. Each statistic is a 16-bit counter. A counter stops at its highest value instead of wrapping, and it returns to zero when the host reads it.

The counters track these errors:
- bad received symbols;
- premature frame ends at 100 Mb/s;
- frame-end errors at 10 Mb/s;
- transmit jabber detections at 10 Mb/s.

The bad-symbol counter does not count every bad symbol. While a frame is in progress, it adds one for each unbroken run of six bad symbols.

The host reads a counter through a small register port. It places a 5-bit address, asserts a read strobe for one cycle, and receives the value on the next cycle. The read returns the value the counter held before the clear. An error that arrives in the same cycle as the read is not lost: the counter restarts at one.

Top module: `phy_err_stat_bank`

## Requirements
- R1: Every counter is 16 bits wide and starts at zero. Each cycle with its event input high adds one. The address map is: bad-symbol counter at 22, 100 Mb/s premature-end counter at 23, 10 Mb/s frame-end error counter at 24, jabber counter at 25. The counters are independent of one another.
- R2: A counter that holds 16'hFFFF keeps that value while further events arrive.
- R3: A read of a counter, with no event in that cycle, returns the counter's prior value and leaves the counter at zero.
- R4: `rd_data` and `rd_valid` are registered. They reflect a read strobe on the clock edge that follows it, and `rd_valid` is high for exactly that one cycle.
- R5: While `frame_active` is high, each group of six bad symbols in a row adds one to the bad-symbol counter. A bad symbol is a cycle with `sym_strobe` and `sym_bad` both high. For example, thirteen bad symbols in a row give a count of two.
- R6: The run of bad symbols starts again from zero on a good symbol (`sym_strobe` high, `sym_bad` low) and whenever `frame_active` is low. A run shorter than six adds nothing.
- R7: If an event arrives in the same cycle as a read of its counter, the read returns the old value and the counter becomes one.
- R8: A read of any address other than 22 to 25 returns zero and leaves every counter unchanged.
- R9: A synchronous active-high `rst` clears all counters, the bad-symbol run, `rd_data` and `rd_valid`.
- R10: Symbol strobes that arrive while `frame_active` is low do not change the bad-symbol counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_active | input | 1 | High while a received frame is in progress |
| sym_strobe | input | 1 | One received symbol is present this cycle |
| sym_bad | input | 1 | The present symbol is bad |
| pre_eof_100 | input | 1 | Premature frame-end event at 100 Mb/s |
| eof_err_10 | input | 1 | Frame-end error event at 10 Mb/s |
| jabber_10 | input | 1 | Transmit jabber detect event at 10 Mb/s |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Register address |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | High for one cycle, one cycle after a read strobe |

## Verification
The bad-symbol grouping is driven with several symbol patterns:
- A run of thirteen bad symbols yields a count of two, which separates true grouping from counting every symbol or rounding up a partial group.
- Runs of five that are broken by a good symbol or by the end of a frame must add nothing, which shows that the run restarts.
- Strobes outside a frame must also add nothing, which shows the frame qualifier is honoured.

The other three counters are driven with different event totals, which shows they are independent. The jabber counter is pushed past 65535 events to show it saturates and is then cleared by a read. A read that coincides with an event shows the old value is returned and the event is kept. A read of an unused address, followed by a read of a loaded counter, shows the unused read has no side effects.

// File: rtl/err_stat_pkg.sv
package err_stat_pkg;

    localparam int CNT_W     = 16;
    localparam int ADDR_W    = 5;
    localparam int NUM_CH    = 4;
    localparam int GROUP_LEN = 6;
    localparam int BASE_ADDR = 22;

    typedef enum logic [1:0] {
        CH_SYMBOL  = 2'd0,
        CH_PREEOF  = 2'd1,
        CH_EOF10   = 2'd2,
        CH_JABBER  = 2'd3
    } chan_e;

    typedef struct packed {
        logic             en;
        logic [ADDR_W-1:0] addr;
    } rd_req_t;

    // Next value of a saturating clear-on-read counter.
    function automatic logic [CNT_W-1:0] sat_step(
        input logic [CNT_W-1:0] cur,
        input logic             evt,
        input logic             clr
    );
        logic [CNT_W-1:0] top_val;
        top_val = '1;
        if (clr)
            sat_step = evt ? CNT_W'(1) : '0;
        else if (evt && cur != top_val)
            sat_step = cur + CNT_W'(1);
        else
            sat_step = cur;
    endfunction

    // True when the address selects channel idx.
    function automatic logic addr_hits(
        input logic [ADDR_W-1:0] addr,
        input int                base,
        input int                idx
    );
        addr_hits = (addr == ADDR_W'(base + idx));
    endfunction

endpackage

// File: rtl/err_sym_grouper.sv
module err_sym_grouper
    import err_stat_pkg::*;
#(
    parameter int GRP = GROUP_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_active,
    input  logic sym_strobe,
    input  logic sym_bad,
    output logic grp_evt
);
    localparam int RUN_W = (GRP > 1) ? $clog2(GRP) : 1;

    logic [RUN_W-1:0] run_q;
    logic             bad_hit;
    logic             good_hit;

    always_comb begin
        bad_hit  = frame_active && sym_strobe && sym_bad;
        good_hit = frame_active && sym_strobe && !sym_bad;
        grp_evt  = bad_hit && (run_q == RUN_W'(GRP - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !frame_active || good_hit) begin
            run_q <= '0;
        end else if (bad_hit) begin
            if (run_q == RUN_W'(GRP - 1))
                run_q <= '0;
            else
                run_q <= run_q + RUN_W'(1);
        end
    end

endmodule

// File: rtl/err_sat_counter.sv
module err_sat_counter
    import err_stat_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic [W-1:0] full_val;

    always_comb begin
        full_val = '1;
        if (clr)
            cnt_d = evt ? W'(1) : '0;
        else if (evt && cnt_q != full_val)
            cnt_d = cnt_q + W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/err_read_mux.sv
module err_read_mux
    import err_stat_pkg::*;
#(
    parameter int W     = CNT_W,
    parameter int AW    = ADDR_W,
    parameter int NCH   = NUM_CH,
    parameter int BASE  = BASE_ADDR
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic [AW-1:0]         rd_addr,
    input  logic [NCH-1:0][W-1:0] cnt,
    output logic [NCH-1:0]        clr,
    output logic [W-1:0]          rd_data,
    output logic                  rd_valid
);
    logic [W-1:0] sel_val;

    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NCH; i++) begin
            clr[i] = rd_en && (rd_addr == AW'(BASE + i));
            if (rd_addr == AW'(BASE + i))
                sel_val = sel_val | cnt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= sel_val;
        end
    end

endmodule

// File: rtl/phy_err_stat_bank.sv
module phy_err_stat_bank
    import err_stat_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int AW   = ADDR_W,
    parameter int GRP  = GROUP_LEN,
    parameter int BASE = BASE_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_active,
    input  logic          sym_strobe,
    input  logic          sym_bad,
    input  logic          pre_eof_100,
    input  logic          eof_err_10,
    input  logic          jabber_10,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int NCH = NUM_CH;

    logic                  sym_grp_evt;
    logic [NCH-1:0]        ch_evt;
    logic [NCH-1:0]        ch_clr;
    logic [NCH-1:0][CW-1:0] ch_cnt;

    err_sym_grouper #(.GRP(GRP)) u_grouper (
        .clk          (clk),
        .rst          (rst),
        .frame_active (frame_active),
        .sym_strobe   (sym_strobe),
        .sym_bad      (sym_bad),
        .grp_evt      (sym_grp_evt)
    );

    always_comb begin
        ch_evt[CH_SYMBOL] = sym_grp_evt;
        ch_evt[CH_PREEOF] = pre_eof_100;
        ch_evt[CH_EOF10]  = eof_err_10;
        ch_evt[CH_JABBER] = jabber_10;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        err_sat_counter #(.W(CW)) u_cnt (
            .clk (clk),
            .rst (rst),
            .evt (ch_evt[g]),
            .clr (ch_clr[g]),
            .cnt (ch_cnt[g])
        );
    end

    err_read_mux #(.W(CW), .AW(AW), .NCH(NCH), .BASE(BASE)) u_rdmux (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .cnt      (ch_cnt),
        .clr      (ch_clr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/phy_err_stat_bank_chk.sv
module phy_err_stat_bank_chk
    import err_stat_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int AW   = ADDR_W,
    parameter int NCH  = NUM_CH,
    parameter int BASE = BASE_ADDR
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   rd_en,
    input logic [AW-1:0]          rd_addr,
    input logic [CW-1:0]          rd_data,
    input logic                   rd_valid,
    input logic [NCH-1:0]         ch_evt,
    input logic [NCH-1:0][CW-1:0] ch_cnt
);
    logic addr_in_map;
    assign addr_in_map = (rd_addr >= AW'(BASE)) && (rd_addr < AW'(BASE + NCH));

    // R4: valid follows the strobe by one cycle
    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    assert_valid_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R8: unused addresses read as zero
    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !addr_in_map) |=> rd_data == '0);

    // R9: reset clears everything
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (ch_cnt == '0 && !rd_valid && rd_data == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        localparam logic [AW-1:0] A = AW'(BASE + g);

        // R2: a full counter stays full
        assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
            (ch_cnt[g] == '1 && !(rd_en && rd_addr == A)) |=> ch_cnt[g] == '1);

        // R1: one event adds one below the maximum
        assert_increment_R1: assert property (@(posedge clk) disable iff (rst)
            (ch_evt[g] && ch_cnt[g] != '1 && !(rd_en && rd_addr == A))
            |=> ch_cnt[g] == $past(ch_cnt[g]) + CW'(1));

        // R3: read without event clears
        assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == A && !ch_evt[g]) |=> ch_cnt[g] == '0);

        // R7: read with event restarts at one, old value returned
        assert_race_keeps_R7: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == A && ch_evt[g]) |=> ch_cnt[g] == CW'(1));
        assert_read_old_R7: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == A) |=> rd_data == $past(ch_cnt[g]));
    end

endmodule

bind phy_err_stat_bank phy_err_stat_bank_chk #(
    .CW(CW), .AW(AW), .NCH(NCH), .BASE(BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .ch_evt   (ch_evt),
    .ch_cnt   (ch_cnt)
);

// File: tb/phy_err_stat_bank_bench.sv
module phy_err_stat_bank_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_SYM = 5'd22;
    localparam logic [4:0] A_PRE = 5'd23;
    localparam logic [4:0] A_EOF = 5'd24;
    localparam logic [4:0] A_JAB = 5'd25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_active = 1'b0;
    logic        sym_strobe = 1'b0;
    logic        sym_bad = 1'b0;
    logic        pre_eof_100 = 1'b0;
    logic        eof_err_10 = 1'b0;
    logic        jabber_10 = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_err_stat_bank u_phy_err_stat_bank (
        .clk(clk), .rst(rst), .frame_active(frame_active),
        .sym_strobe(sym_strobe), .sym_bad(sym_bad),
        .pre_eof_100(pre_eof_100), .eof_err_10(eof_err_10),
        .jabber_10(jabber_10), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read one register; returns data seen one cycle after the strobe.
    task automatic do_read(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
        check("R4 valid", {15'd0, rd_valid}, 16'd1);
    endtask

    task automatic pulse(input int ch, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pre_eof_100 = (ch == 1);
            eof_err_10  = (ch == 2);
            jabber_10   = (ch == 3);
        end
        @(negedge clk);
        pre_eof_100 = 0; eof_err_10 = 0; jabber_10 = 0;
    endtask

    task automatic sym(input logic bad);
        @(negedge clk);
        sym_strobe = 1'b1;
        sym_bad = bad;
        @(negedge clk);
        sym_strobe = 1'b0;
        sym_bad = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        check("R9 rd_valid after reset", {15'd0, rd_valid}, 16'd0);
        check("R9 rd_data after reset", rd_data, 16'd0);
        for (int a = 22; a < 26; a++) begin
            do_read(5'(a), v);
            check("R9 counter zero", v, 16'd0);
        end
        pulse(1, 4);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        do_read(A_PRE, v);
        check("R9 reset clears loaded counter", v, 16'd0);
    endtask

    task automatic t_channels();
        logic [15:0] v;
        pulse(1, 3);
        pulse(2, 5);
        pulse(3, 7);
        do_read(A_PRE, v); check("R1 premature-end count", v, 16'd3);
        do_read(A_EOF, v); check("R1 frame-end error count", v, 16'd5);
        do_read(A_JAB, v); check("R1 jabber count", v, 16'd7);
        do_read(A_SYM, v); check("R1 symbol counter untouched", v, 16'd0);
        do_read(A_PRE, v); check("R3 clear on read", v, 16'd0);
        do_read(A_JAB, v); check("R3 clear on read jabber", v, 16'd0);
    endtask

    task automatic t_symbols();
        logic [15:0] v;
        @(negedge clk); frame_active = 1'b1;
        for (int i = 0; i < 13; i++) sym(1'b1);
        do_read(A_SYM, v);
        check("R5 thirteen bad symbols give two", v, 16'd2);
        // leftover 1 + 5 more -> six in a row, but frame ended first
        @(negedge clk); frame_active = 1'b0;
        @(negedge clk); frame_active = 1'b1;
        for (int i = 0; i < 5; i++) sym(1'b1);
        sym(1'b0);
        for (int i = 0; i < 5; i++) sym(1'b1);
        @(negedge clk); frame_active = 1'b0;
        @(negedge clk); frame_active = 1'b1;
        for (int i = 0; i < 5; i++) sym(1'b1);
        do_read(A_SYM, v);
        check("R6 broken runs add nothing", v, 16'd0);
        sym(1'b0);
        for (int i = 0; i < 6; i++) sym(1'b1);
        do_read(A_SYM, v);
        check("R5 exact group of six", v, 16'd1);
        @(negedge clk); frame_active = 1'b0;
        for (int i = 0; i < 12; i++) sym(1'b1);
        do_read(A_SYM, v);
        check("R10 symbols outside frame ignored", v, 16'd0);
    endtask

    task automatic t_saturate();
        logic [15:0] v;
        pulse(3, 65535 + 5);
        do_read(A_JAB, v);
        check("R2 saturates at max", v, 16'hFFFF);
        do_read(A_JAB, v);
        check("R3 clear after saturation", v, 16'd0);
    endtask

    task automatic t_race();
        logic [15:0] v;
        pulse(1, 3);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = A_PRE; pre_eof_100 = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; pre_eof_100 = 1'b0;
        check("R7 read returns old value", rd_data, 16'd3);
        do_read(A_PRE, v);
        check("R7 coincident event kept", v, 16'd1);
    endtask

    task automatic t_unused();
        logic [15:0] v;
        pulse(2, 4);
        do_read(5'd5, v);
        check("R8 unused address reads zero", v, 16'd0);
        do_read(5'd26, v);
        check("R8 address above map reads zero", v, 16'd0);
        do_read(A_EOF, v);
        check("R8 no side effect on counter", v, 16'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_channels();
        t_symbols();
        t_saturate();
        t_race();
        t_unused();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule